// File: doc/BRIEF.md
# Constant-Off-Time Bridge Current Limiter

This controller sits between the digitised current and temperature sensing of a motor H-bridge and its gate-drive logic. It receives single-bit comparator results for the load-current limit, the high-side short threshold, the low-side short threshold, and a flag that reports an over-hot junction. From these it produces three outputs. The first asks the gate driver to turn every bridge switch off. The second selects which current-limit threshold the comparator uses. The third is a one-cycle short-circuit pulse sent to a fault latch outside the block. All durations are counted in clock cycles.

Whenever the commanded output levels change, the limiter opens a blanking window. During this window the current-limit comparator is not trusted, because switching transients would make it trip falsely. If the limit comparator fires outside that window, the bridge is switched off for a fixed number of cycles. Drive then resumes at the commanded levels, and a fresh blanking window opens. Each limit cycle is therefore at least the off time plus the blanking time long, which bounds the switching rate in limit mode. The two short comparators are watched at all times, including during blanking and off time. Either one shuts the bridge off at once and holds it off until reset. While the junction is hot, the threshold select output asks for the reduced limit.

With a 250 MHz clock, the defaults give an off time of about 20 µs and a blanking time of about 16.5 µs.

Top module: `ilim_offtime_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, bridge_off, short_fault and fold_sel are 0. Reset also opens a blanking window, so ilim_hit is ignored on the first BLANK_CYC clock edges after reset is released.
- R2: A change of any bit of drive_cmd opens a blanking window. ilim_hit is ignored on the edge that registers the change and on the BLANK_CYC edges that follow it.
- R3: If ilim_hit is 1 on an edge where the bridge is driving and no blanking window is open, bridge_off is 1 from the next cycle for exactly OFF_CYC cycles.
- R4: ilim_hit held at 1 during an off period neither extends it nor restarts it.
- R5: The edge that ends an off period opens a new blanking window. With ilim_hit held at 1, bridge_off therefore stays 0 for exactly BLANK_CYC+1 cycles before the next off period.
- R6: If hs_short or ls_short is 1 on an edge, in any state other than a latched fault (this includes blanking and off time), then on the next cycle bridge_off is 1 and short_fault is 1.
- R7: After a short, bridge_off stays 1 whatever the other inputs do, and short_fault stays 0 after its single cycle. Only rst clears the fault.
- R8: fold_sel equals hot_flag delayed by one clock cycle. 1 requests the reduced current limit.
- R9: If drive_cmd changes on the same edge as ilim_hit is 1, the change takes priority and the bridge is not switched off.
- R10: The blanking and off-time counters stop at zero and never wrap. After a long idle time without command changes, ilim_hit switches the bridge off on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_cmd | input | CMD_W | Commanded half-bridge levels; any change counts as an output transition |
| ilim_hit | input | 1 | Load-current limit comparator result |
| hs_short | input | 1 | High-side short comparator result (output shorted to ground) |
| ls_short | input | 1 | Low-side short comparator result (output shorted to supply) |
| hot_flag | input | 1 | Junction above the foldback temperature |
| bridge_off | output | 1 | Request to turn all bridge switches off |
| fold_sel | output | 1 | Threshold select: 1 selects the reduced current limit |
| short_fault | output | 1 | One-cycle pulse to the external fault latch on a detected short |

## Verification
The assertions check the following on every cycle: a limit hit during an open window never starts an off period; an off period is not cut short or extended while its timer runs; the resume edge always reopens blanking; a short always produces the off request together with the pulse; the fault state never releases; and the counters neither wrap nor skip. Some behaviour can only be shown by the bench scenarios, because it depends on exact cycle counts across several events. These are the window length seen from the command input, swept one edge at a time; the precise off and drive lengths under a limit hit held continuously; the same-edge priority of a command change; and fault holding while commands and limit hits keep arriving.

// File: rtl/ilim_ctrl_pkg.sv
package ilim_ctrl_pkg;

    typedef enum logic [1:0] {
        BR_DRIVE = 2'd0,
        BR_OFF   = 2'd1,
        BR_FAULT = 2'd2
    } br_state_e;

    typedef struct packed {
        logic ilim;
        logic hs_short;
        logic ls_short;
        logic hot;
    } sense_t;

    function automatic br_state_e next_state(
        input br_state_e cur,
        input logic      short_any,
        input logic      trip,
        input logic      resume
    );
        if (cur != BR_FAULT && short_any) return BR_FAULT;
        if (trip)                         return BR_OFF;
        if (resume)                       return BR_DRIVE;
        return cur;
    endfunction

endpackage

// File: rtl/ilim_cmd_edge.sv
module ilim_cmd_edge #(
    parameter int unsigned CMD_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd,
    output logic             changed
);
    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd;
    end

    assign changed = (cmd != cmd_q);

    // R2: a command held for two edges produces no further transition
    a_r2_edge_once: assert property (@(posedge clk) disable iff (rst)
        (changed && $stable(cmd)) |=> !changed);
endmodule

// File: rtl/ilim_sat_timer.sv
module ilim_sat_timer #(
    parameter int unsigned MAX_CNT    = 4,
    parameter bit          START_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy,
    output logic last
);
    localparam int unsigned W = $clog2(MAX_CNT + 1);
    localparam logic [W-1:0] FULL = W'(MAX_CNT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= START_FULL ? FULL : '0;
        else if (load)      cnt <= FULL;
        else if (cnt != '0) cnt <= cnt - W'(1);
    end

    assign busy = (cnt != '0);
    assign last = (cnt == W'(1));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> cnt == '0);
    a_r10_step: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> cnt == $past(cnt) - W'(1));
    a_r10_load: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == FULL);
endmodule

// File: rtl/ilim_offtime_ctrl.sv
module ilim_offtime_ctrl
    import ilim_ctrl_pkg::*;
#(
    parameter int unsigned OFF_CYC   = 5000,
    parameter int unsigned BLANK_CYC = 4125,
    parameter int unsigned CMD_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] drive_cmd,
    input  logic             ilim_hit,
    input  logic             hs_short,
    input  logic             ls_short,
    input  logic             hot_flag,
    output logic             bridge_off,
    output logic             fold_sel,
    output logic             short_fault
);
    sense_t    sense;
    br_state_e state, state_nx;
    logic      cmd_chg, short_any, trip, resume;
    logic      blank_busy, blank_last, blank_load;
    logic      off_busy, off_last;

    assign sense = '{ilim: ilim_hit, hs_short: hs_short,
                     ls_short: ls_short, hot: hot_flag};

    ilim_cmd_edge #(.CMD_W(CMD_W)) u_edge (
        .clk(clk), .rst(rst), .cmd(drive_cmd), .changed(cmd_chg)
    );

    assign short_any = sense.hs_short | sense.ls_short;
    assign trip      = (state == BR_DRIVE) && !blank_busy && sense.ilim && !cmd_chg;
    assign resume    = (state == BR_OFF) && off_last;
    assign blank_load = (state != BR_FAULT) && !short_any && (cmd_chg || resume);

    ilim_sat_timer #(.MAX_CNT(BLANK_CYC), .START_FULL(1'b1)) u_blank (
        .clk(clk), .rst(rst), .load(blank_load),
        .busy(blank_busy), .last(blank_last)
    );

    ilim_sat_timer #(.MAX_CNT(OFF_CYC), .START_FULL(1'b0)) u_off (
        .clk(clk), .rst(rst), .load(trip && !short_any),
        .busy(off_busy), .last(off_last)
    );

    assign state_nx = next_state(state, short_any, trip, resume);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= BR_DRIVE;
            short_fault <= 1'b0;
            fold_sel    <= 1'b0;
        end else begin
            state       <= state_nx;
            short_fault <= (state != BR_FAULT) && short_any;
            fold_sel    <= sense.hot;
        end
    end

    assign bridge_off = (state != BR_DRIVE);

    a_r2_blank_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == BR_DRIVE && blank_busy && !short_any) |=> state != BR_OFF);
    a_r3_off_timer_runs: assert property (@(posedge clk) disable iff (rst)
        (state == BR_OFF) |-> off_busy);
    a_r4_off_fixed: assert property (@(posedge clk) disable iff (rst)
        (state == BR_OFF && !off_last && !short_any) |=> state == BR_OFF);
    a_r5_resume_blanks: assert property (@(posedge clk) disable iff (rst)
        (state == BR_OFF && off_last && !short_any) |=> (state == BR_DRIVE && blank_busy));
    a_r6_short_off: assert property (@(posedge clk) disable iff (rst)
        (state != BR_FAULT && short_any) |=> (bridge_off && short_fault));
    a_r7_fault_holds: assert property (@(posedge clk) disable iff (rst)
        (state == BR_FAULT) |=> (state == BR_FAULT && !short_fault));
    a_r8_fold_high: assert property (@(posedge clk) disable iff (rst)
        hot_flag |=> fold_sel);
    a_r8_fold_low: assert property (@(posedge clk) disable iff (rst)
        !hot_flag |=> !fold_sel);
    a_r9_change_wins: assert property (@(posedge clk) disable iff (rst)
        (state == BR_DRIVE && cmd_chg && !short_any) |=> state == BR_DRIVE);
    a_r10_blank_end: assert property (@(posedge clk) disable iff (rst)
        (blank_last && !blank_load) |=> !blank_busy);
endmodule

// File: tb/ilim_offtime_ctrl_test.sv
module ilim_offtime_ctrl_test;
    localparam int unsigned OFF = 5;
    localparam int unsigned BLK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] drive_cmd = 2'd0;
    logic       ilim_hit = 1'b0, hs_short = 1'b0, ls_short = 1'b0, hot_flag = 1'b0;
    logic       bridge_off, fold_sel, short_fault;

    int checks = 0;
    int errors = 0;
    int run_len;
    int bad;

    always #2 clk = ~clk;

    ilim_offtime_ctrl #(.OFF_CYC(OFF), .BLANK_CYC(BLK), .CMD_W(2)) uut (
        .clk(clk), .rst(rst), .drive_cmd(drive_cmd), .ilim_hit(ilim_hit),
        .hs_short(hs_short), .ls_short(ls_short), .hot_flag(hot_flag),
        .bridge_off(bridge_off), .fold_sel(fold_sel), .short_fault(short_fault)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_of(input logic lvl, output int n);
        n = 0;
        while (bridge_off == lvl && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ilim_hit = 1'b0; hs_short = 1'b0; ls_short = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 bridge_off in reset", bridge_off, 0);
        check("R1 short_fault in reset", short_fault, 0);
        check("R1 fold_sel in reset", fold_sel, 0);

        // R1/R3/R5/R4: release reset with ilim held high
        ilim_hit = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        check("R1 short_fault after reset", short_fault, 0);
        run_of(1'b0, run_len);
        check("R1 blank after reset", run_len, BLK);
        run_of(1'b1, run_len);
        check("R3 off length", run_len, OFF);
        run_of(1'b0, run_len);
        check("R5 drive after resume", run_len, BLK + 1);
        run_of(1'b1, run_len);
        check("R4 off not extended", run_len, OFF);
        ilim_hit = 1'b0;
        repeat (OFF + BLK + 6) @(negedge clk);

        // R2/R9: sweep hit position relative to a command change
        for (int d = 0; d <= BLK + 3; d++) begin
            drive_cmd = drive_cmd + 2'd1;
            if (d == 0) ilim_hit = 1'b1;
            else begin
                repeat (d) @(negedge clk);
                ilim_hit = 1'b1;
            end
            @(negedge clk);
            ilim_hit = 1'b0;
            if (d == 0) check("R9 change beats hit", bridge_off, 0);
            else        check("R2 blank window sweep", bridge_off, (d >= BLK + 1) ? 1 : 0);
            repeat (OFF + BLK + 4) @(negedge clk);
        end

        // R10: long idle, hit acts on next cycle
        repeat (40) @(negedge clk);
        ilim_hit = 1'b1;
        @(negedge clk);
        ilim_hit = 1'b0;
        check("R10 no wrap after idle", bridge_off, 1);
        repeat (OFF + BLK + 4) @(negedge clk);

        // R8: foldback select
        hot_flag = 1'b1;
        @(negedge clk);
        check("R8 fold high", fold_sel, 1);
        hot_flag = 1'b0;
        @(negedge clk);
        check("R8 fold low", fold_sel, 0);

        // R6/R7: shorts in drive, blank and off contexts
        for (int ctx = 0; ctx < 3; ctx++) begin
            for (int side = 0; side < 2; side++) begin
                do_reset();
                repeat (BLK + 3) @(negedge clk);
                if (ctx == 1) begin
                    drive_cmd = drive_cmd + 2'd1;
                    @(negedge clk);
                end else if (ctx == 2) begin
                    ilim_hit = 1'b1;
                    @(negedge clk);
                    ilim_hit = 1'b0;
                    check("R3 off before short", bridge_off, 1);
                end
                if (side == 0) hs_short = 1'b1;
                else           ls_short = 1'b1;
                @(negedge clk);
                hs_short = 1'b0;
                ls_short = 1'b0;
                check("R6 short turns off", bridge_off, 1);
                check("R6 short pulse", short_fault, 1);
                bad = 0;
                for (int c = 0; c < 2 * (OFF + BLK); c++) begin
                    @(negedge clk);
                    if (!bridge_off || short_fault) bad++;
                    drive_cmd = drive_cmd + 2'd1;
                    ilim_hit = c[0];
                    hs_short = (c == 5);
                end
                ilim_hit = 1'b0;
                hs_short = 1'b0;
                check("R7 fault held", bad, 0);
                do_reset();
                @(negedge clk);
                check("R7 reset clears", bridge_off, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule